// File: doc/BRIEF.md
# Streaming Bit-Reversal Reorder Buffer

A pipelined decimation-in-frequency FFT emits its bins in bit-reversed order. This block sits after such a pipeline and puts the stream back into natural frequency order without stopping it. It holds two frame-sized banks of complex samples. Each accepted input sample is written into one bank at a linear slot. In the same step, the other bank, which holds the previous complete frame, is read at the bit-reversed slot. When a frame finishes, the two banks trade roles.

The output is paced by the input. Every accepted input step yields one output step, registered one cycle later, so the block adds one full frame of delay. A sync flag on the input marks the first sample of a frame. If it arrives while a frame is only partly written, the block drops that partial frame and realigns. Total storage is 2N complex samples for an N-point transform.

Top module: `brev_reorder`

## Requirements
- R1: After reset, `out_valid` and `out_start` are low, and they stay low while no input is accepted.
- R2: The write slot advances by one for each accepted sample. After slot N-1 it wraps to 0 and the banks swap, even when no sync is given, so frames follow one another with no sync at all.
- R3: At output step k of a frame period, where k is the write slot of the accepted input (slot 0 is the first sample of a frame), the output carries the sample written at slot bitrev(k) of the previous complete frame. bitrev reverses all log2(N) bits. `out_re` and `out_im` are the real and imaginary halves.
- R4: The output for an accepted input step appears on the first rising edge after that input is accepted. With gapless input, each output is therefore N+1 cycles behind the same-slot input of the previous frame.
- R5: No output is valid until a first complete frame of N samples has been written.
- R6: `out_start` is high only with `out_valid`, only on output step k = 0, and valid outputs between two starts number exactly N.
- R7: There is exactly one output per accepted input. A cycle with `in_valid` low produces `out_valid` low on the following edge.
- R8: An accepted sample with `in_sync` high is written at slot 0. If the write slot was not 0, the partial frame and the frame being read out are both discarded, and there is no output until a new complete frame has been written.
- R9: `in_sync` on a sample that already falls at slot 0 has no effect, and output continues without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample accepted this cycle |
| in_sync | input | 1 | Input sample is the first of a frame |
| in_re | input | DATA_W | Real part of the input sample |
| in_im | input | DATA_W | Imaginary part of the input sample |
| out_valid | output | 1 | Output sample valid |
| out_start | output | 1 | Output sample is bin 0 of a frame |
| out_re | output | DATA_W | Real part of the output sample |
| out_im | output | DATA_W | Imaginary part of the output sample |

## Verification
The bench builds the block with N = 8 and 8-bit components. Every slot of every frame is then checked against a value computed from the frame number and the bin index, including the full bit-reversed address sequence. This small size also allows runs of gapless frames, frames with no sync, and frames with idle cycles between samples. It also reaches resyncs both early in a frame and at the last slot N-1, where a wrap and a resync compete for the same sample.

// File: rtl/brev_pkg.sv
package brev_pkg;

  // Which of the two frame banks is meant.
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  // Per-cycle write-side events.
  typedef struct packed {
    logic accept;   // a sample is taken this cycle
    logic resync;   // sync arrived with the slot counter off zero
  } wr_evt_t;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction

endpackage

// File: rtl/brev_wr_ctrl.sv
module brev_wr_ctrl
  import brev_pkg::*;
#(
  parameter int N_PTS  = 64,
  parameter int ADDR_W = $clog2(N_PTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sync,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] wr_slot,
  output bank_e             wr_bank,
  output logic              frm_ok,
  output wr_evt_t           evt
);

  localparam logic [ADDR_W-1:0] LAST_SLOT = ADDR_W'(N_PTS - 1);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  bank_e             bank_q, bank_d;
  logic              ok_q, ok_d;
  logic              wrap_c;
  logic [ADDR_W-1:0] slot_c;

  // Next-state logic
  always_comb begin
    slot_c     = in_sync ? '0 : ptr_q;
    evt.accept = in_valid;
    evt.resync = in_valid & in_sync & (ptr_q != '0);
    wrap_c     = in_valid & (slot_c == LAST_SLOT);

    ptr_d  = wrap_c ? '0 : slot_c + 1'b1;
    bank_d = wrap_c ? other_bank(bank_q) : bank_q;
    if (evt.resync)  ok_d = 1'b0;
    else if (wrap_c) ok_d = 1'b1;
    else             ok_d = ok_q;
  end

  // State registers, enabled by an accepted sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      bank_q <= BANK_A;
      ok_q   <= 1'b0;
    end else if (in_valid) begin
      ptr_q  <= ptr_d;
      bank_q <= bank_d;
      ok_q   <= ok_d;
    end
  end

  assign wr_ptr  = ptr_q;
  assign wr_slot = slot_c;
  assign wr_bank = bank_q;
  assign frm_ok  = ok_q;

endmodule

// File: rtl/brev_bank.sv
module brev_bank #(
  parameter int ADDR_W = 6,
  parameter int SAMP_W = 32,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [SAMP_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [SAMP_W-1:0] rdata
);

  logic [SAMP_W-1:0] mem [DEPTH];

  // Storage array: no reset, written only when enabled
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/brev_rd_path.sv
module brev_rd_path
  import brev_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SAMP_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_slot,
  input  bank_e                  rd_bank,
  input  logic [1:0][SAMP_W-1:0] bank_rdata,
  output logic [ADDR_W-1:0]      rd_addr,
  output logic                   out_valid,
  output logic                   out_start,
  output logic [SAMP_W-1:0]      out_data
);

  logic [SAMP_W-1:0] sel_data;
  logic              vld_q, vld_d;
  logic              sta_q, sta_d;
  logic [SAMP_W-1:0] dat_q;

  // Read address is the slot with its bits mirrored
  for (genvar b = 0; b < ADDR_W; b++) begin : g_rev
    assign rd_addr[b] = rd_slot[ADDR_W-1-b];
  end

  // Next-state logic
  always_comb begin
    sel_data = (rd_bank == BANK_B) ? bank_rdata[1] : bank_rdata[0];
    vld_d    = rd_en;
    sta_d    = rd_en & (rd_slot == '0);
  end

  // Control flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sta_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      sta_q <= sta_d;
    end
  end

  // Data register, enabled only on a read step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (rd_en) begin
      dat_q <= sel_data;
    end
  end

  assign out_valid = vld_q;
  assign out_start = sta_q;
  assign out_data  = dat_q;

endmodule

// File: rtl/brev_reorder.sv
module brev_reorder
  import brev_pkg::*;
#(
  parameter int N_PTS  = 64,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sync,
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  output logic              out_valid,
  output logic              out_start,
  output logic [DATA_W-1:0] out_re,
  output logic [DATA_W-1:0] out_im
);

  localparam int ADDR_W = $clog2(N_PTS);
  localparam int SAMP_W = 2 * DATA_W;

  logic [ADDR_W-1:0]      wr_ptr;
  logic [ADDR_W-1:0]      wr_slot;
  bank_e                  wr_bank;
  bank_e                  rd_bank;
  logic                   frm_ok;
  wr_evt_t                evt;
  logic                   rd_en;
  logic [ADDR_W-1:0]      rd_addr;
  logic [SAMP_W-1:0]      wdata;
  logic [1:0][SAMP_W-1:0] bank_rdata;
  logic [SAMP_W-1:0]      out_data;

  brev_wr_ctrl #(
    .N_PTS (N_PTS),
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_sync (in_sync),
    .wr_ptr  (wr_ptr),
    .wr_slot (wr_slot),
    .wr_bank (wr_bank),
    .frm_ok  (frm_ok),
    .evt     (evt)
  );

  assign wdata   = {in_re, in_im};
  assign rd_bank = other_bank(wr_bank);
  assign rd_en   = evt.accept & frm_ok & ~evt.resync;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    localparam bank_e MY_BANK = (g == 0) ? BANK_A : BANK_B;
    logic we;
    assign we = evt.accept & (wr_bank == MY_BANK);

    brev_bank #(
      .ADDR_W(ADDR_W),
      .SAMP_W(SAMP_W)
    ) u_bank (
      .clk  (clk),
      .we   (we),
      .waddr(wr_slot),
      .wdata(wdata),
      .raddr(rd_addr),
      .rdata(bank_rdata[g])
    );
  end

  brev_rd_path #(
    .ADDR_W(ADDR_W),
    .SAMP_W(SAMP_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_slot   (wr_slot),
    .rd_bank   (rd_bank),
    .bank_rdata(bank_rdata),
    .rd_addr   (rd_addr),
    .out_valid (out_valid),
    .out_start (out_start),
    .out_data  (out_data)
  );

  assign out_re = out_data[SAMP_W-1:DATA_W];
  assign out_im = out_data[DATA_W-1:0];

endmodule

// File: rtl/brev_reorder_chk.sv
module brev_reorder_chk #(
  parameter int N_PTS  = 64,
  parameter int ADDR_W = $clog2(N_PTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_sync,
  input logic              out_valid,
  input logic              out_start,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic              wr_bank
);

  localparam logic [ADDR_W-1:0] LAST_SLOT = ADDR_W'(N_PTS - 1);
  localparam logic [ADDR_W:0]   FRAME_LEN = (ADDR_W + 1)'(N_PTS);

  logic [ADDR_W:0] run_cnt;
  logic            run_seen;
  logic            resync_ev;

  assign resync_ev = in_valid & in_sync & (wr_ptr != '0);

  // Counts valid outputs since the last frame start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      run_seen <= 1'b0;
    end else begin
      if (out_valid) begin
        if (out_start) begin
          run_cnt  <= (ADDR_W + 1)'(1);
          run_seen <= 1'b1;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end
      if (resync_ev) begin
        run_seen <= 1'b0;
      end
    end
  end

  AST_START_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid); // R6

  AST_FRAME_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_start && run_seen) |-> (run_cnt == FRAME_LEN)); // R6

  AST_ONE_OUT_PER_IN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R7

  AST_RESYNC_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    resync_ev |=> !out_valid); // R8

  AST_BANK_SWAP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_bank) |-> $past(in_valid && !in_sync && wr_ptr == LAST_SLOT)); // R2

endmodule

bind brev_reorder brev_reorder_chk #(.N_PTS(N_PTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_sync  (in_sync),
  .out_valid(out_valid),
  .out_start(out_start),
  .wr_ptr   (wr_ptr),
  .wr_bank  (wr_bank)
);

// File: tb/brev_reorder_test.sv
module brev_reorder_test;

  localparam int N  = 8;
  localparam int W  = 8;
  localparam int AW = 3;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_sync;
  logic [W-1:0] in_re;
  logic [W-1:0] in_im;
  logic         out_valid;
  logic         out_start;
  logic [W-1:0] out_re;
  logic [W-1:0] out_im;

  int n_chk;
  int n_bad;
  bit prev_ok;
  int prev_fid;
  int slot;

  brev_reorder #(.N_PTS(N), .DATA_W(W)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sync  (in_sync),
    .in_re    (in_re),
    .in_im    (in_im),
    .out_valid(out_valid),
    .out_start(out_start),
    .out_re   (out_re),
    .out_im   (out_im)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  function automatic int brev_i(input int v);
    int r;
    r = 0;
    for (int b = 0; b < AW; b++) if (v[b]) r = r | (1 << (AW - 1 - b));
    return r;
  endfunction

  function automatic logic [W-1:0] re_of(input int fid, input int bin);
    return W'((fid * N + bin) & 255);
  endfunction

  function automatic logic [W-1:0] im_of(input int fid, input int bin);
    return ~re_of(fid, bin);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One clock step: drive after the falling edge, sample just after the rising edge.
  task automatic step(input bit v, input bit s, input logic [W-1:0] re, input logic [W-1:0] im,
                      input bit exp_v, input int exp_k, input int exp_fid, input string req);
    @(negedge clk);
    in_valid = v;
    in_sync  = s;
    in_re    = re;
    in_im    = im;
    @(posedge clk);
    #1;
    check(req, "out_valid", int'(out_valid), int'(exp_v));
    if (exp_v) begin
      check("R6", "out_start", int'(out_start), int'(exp_k == 0));
      check("R3", "out_re", int'(out_re), int'(re_of(exp_fid, exp_k)));
      check("R3", "out_im", int'(out_im), int'(im_of(exp_fid, exp_k)));
    end else begin
      check("R6", "out_start idle", int'(out_start), 0);
    end
  endtask

  // Send cnt samples of frame fid in bit-reversed bin order; gap idle cycles after each.
  task automatic send(input int fid, input bit sync, input int cnt, input int gap, input string req);
    for (int j = 0; j < cnt; j++) begin
      int k;
      bit s;
      s = sync && (j == 0);
      if (s && slot != 0) prev_ok = 0;   // R8: partial frame dropped
      k = s ? 0 : slot;
      step(1'b1, s, re_of(fid, brev_i(k)), im_of(fid, brev_i(k)), prev_ok, k, prev_fid, req);
      slot = k + 1;
      if (slot == N) begin
        slot     = 0;
        prev_ok  = 1;
        prev_fid = fid;
      end
      for (int g = 0; g < gap; g++) begin
        step(1'b0, 1'b0, '0, '0, 1'b0, 0, 0, "R7");
      end
    end
  endtask

  initial begin
    n_chk    = 0;
    n_bad    = 0;
    prev_ok  = 0;
    prev_fid = 0;
    slot     = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_sync  = 1'b0;
    in_re    = '0;
    in_im    = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "out_start in reset", int'(out_start), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, '0, 1'b0, 0, 0, "R1");

    send(0, 1'b1, N, 0, "R5");              // first frame: nothing out
    for (int f = 1; f <= 2; f++) send(f, 1'b1, N, 0, "R4");
    for (int f = 3; f <= 4; f++) send(f, 1'b1, N, 0, "R9");
    for (int f = 5; f <= 7; f++) send(f, 1'b0, N, 0, "R2");
    for (int f = 8; f <= 9; f++) send(f, 1'b1, N, 1, "R7");

    send(10, 1'b1, 3, 0, "R4");             // partial frame
    send(11, 1'b1, N, 0, "R8");             // resync mid-frame: silent
    send(12, 1'b0, N, 0, "R8");             // output resumes with frame 11

    send(13, 1'b0, N - 1, 0, "R3");         // stop at slot N-1
    send(14, 1'b1, N, 0, "R8");             // resync at last slot: silent
    send(15, 1'b1, N, 2, "R8");             // resumes with frame 14
    send(16, 1'b0, N, 0, "R2");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule